// File: doc/BRIEF.md
# Branch Resolve Unit with Likely-Slot Annulment

This block sits at the branch stage of a 32-bit RISC pipeline whose branches have one delay slot. For each valid instruction it is handed (the instruction word, both source operand values and the instruction's PC), it reports one clock later:
- whether the instruction is a conditional branch;
- whether that branch is taken;
- the branch target;
- the PC that fetch must use after the delay slot;
- an optional write of a return address to the link register.

Ordinary branches always let their delay slot run. The "likely" branches annul their slot when they are not taken. In that case the block raises a squash flag and remembers it. The next valid instruction it sees is the delay slot, and that instruction is retired as a no-op: its register-write request is withheld, and any branch or link effect it would have had is dropped. Fetch then resumes at the branch PC plus 8.

The reset input is asynchronous and active-low. Its release is resynchronised inside the block, so the first instruction may be offered two clocks after the release.

Top module: `brl_resolve_unit`

## Requirements
- R1: While reset is held, and until the first valid instruction is accepted after release, out_valid, out_is_branch, out_taken, out_squash, out_link_we and out_wr_commit are all low.
- R2: Every result appears exactly one clock after the instruction is offered: out_valid equals in_valid delayed by one clock. For a branch, out_target = PC + 4 + (sign-extended instr[15:0] << 2), using the major opcode in instr[31:26].
- R3: The equality branches are opcode 0x04 (equal) and 0x14 (equal, likely), taken when rs == rt. The inequality branches are 0x05 (not equal) and 0x15 (not equal, likely), taken when rs != rt.
- R4: The zero-compare branches treat rs as a signed value. Opcodes 0x06 and 0x16 are taken when rs <= 0; 0x07 and 0x17 are taken when rs > 0. Under opcode 0x01, instr[20:16] selects the branch: 0x00/0x02/0x10/0x12 are taken when rs < 0, and 0x01/0x03/0x11/0x13 are taken when rs >= 0.
- R5: out_squash is high exactly when a likely branch (0x14, 0x15, 0x16, 0x17, or selector 0x02, 0x03, 0x12, 0x13 under 0x01) is not taken. A taken likely branch does not squash.
- R6: Ordinary branches (0x04–0x07, and selectors 0x00, 0x01, 0x10, 0x11 under 0x01) never raise out_squash, whether taken or not.
- R7: The and-link forms (selectors 0x10–0x13 under opcode 0x01) raise out_link_we with out_link_idx = 31 and out_link_data = PC + 8, whether or not they are taken.
- R8: out_next_pc is the target for a taken branch, PC + 8 for a branch that is not taken, and PC + 4 for any other instruction.
- R9: The first valid instruction after a squash is annulled. It reports out_wr_commit = 0, is not treated as a branch (no taken, squash or link flag), and out_next_pc = PC + 4. Every other valid instruction reports out_wr_commit = in_wr_req.
- R10: Any other opcode, including unused selectors under 0x01, is not a branch: out_is_branch, out_taken, out_squash and out_link_we stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_instr | input | 32 | Instruction word |
| in_rs | input | XLEN | Value of the rs operand |
| in_rt | input | XLEN | Value of the rt operand |
| in_pc | input | XLEN | PC of the instruction |
| in_wr_req | input | 1 | The instruction wants to commit a register or memory write |
| out_valid | output | 1 | Result of the previous cycle's instruction |
| out_is_branch | output | 1 | Instruction is a live conditional branch |
| out_taken | output | 1 | Branch taken |
| out_target | output | XLEN | Branch target address |
| out_squash | output | 1 | Delay slot must be annulled |
| out_next_pc | output | XLEN | Fetch address after this instruction (and its slot) |
| out_link_we | output | 1 | Write return address to the link register |
| out_link_idx | output | 5 | Link register index (31) |
| out_link_data | output | XLEN | Return address PC + 8 |
| out_wr_commit | output | 1 | Write of this instruction may commit |

## Verification
The bench sweeps each compare against operands at the boundary: equal, different, zero, the most negative value and one. A signed/unsigned mix-up would flip the outcome for rs of 0x80000000, and an inverted likely condition would squash taken branches. It places a branch, and an instruction with a write request, in the slot of a squashing branch. A design that forgets the pending annulment would commit that write or redirect fetch from a dead slot. A design that never clears the pending annulment would kill the instruction after the slot as well. It also runs and-link forms both ways, because a design that gates the link on the outcome loses the return address when the branch falls through, and it uses negative offsets to expose a missing sign extension.

// File: rtl/brl_pkg.sv
package brl_pkg;

  localparam int OPC_W = 6;
  localparam int SEL_W = 5;

  localparam logic [OPC_W-1:0] OPC_REGIMM = 6'h01;
  localparam logic [OPC_W-1:0] OPC_EQ     = 6'h04;
  localparam logic [OPC_W-1:0] OPC_NE     = 6'h05;
  localparam logic [OPC_W-1:0] OPC_LEZ    = 6'h06;
  localparam logic [OPC_W-1:0] OPC_GTZ    = 6'h07;
  localparam logic [OPC_W-1:0] OPC_EQ_LK  = 6'h14;
  localparam logic [OPC_W-1:0] OPC_NE_LK  = 6'h15;
  localparam logic [OPC_W-1:0] OPC_LEZ_LK = 6'h16;
  localparam logic [OPC_W-1:0] OPC_GTZ_LK = 6'h17;

  // selector field under OPC_REGIMM: bit 1 = likely, bit 4 = and-link,
  // bit 0 = greater-or-equal (else less-than)
  localparam int SEL_LIKELY_BIT = 1;
  localparam int SEL_LINK_BIT   = 4;
  localparam int SEL_GE_BIT     = 0;

  typedef enum logic [2:0] {
    CND_EQ  = 3'd0,
    CND_NE  = 3'd1,
    CND_LEZ = 3'd2,
    CND_GTZ = 3'd3,
    CND_LTZ = 3'd4,
    CND_GEZ = 3'd5
  } cond_e;

  typedef struct packed {
    logic  is_br;
    logic  likely;
    logic  link;
    cond_e cond;
  } br_dec_t;

endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
(
  input  logic [31:0] instr,
  output br_dec_t     dec
);

  logic [OPC_W-1:0] opc;
  logic [SEL_W-1:0] sel;

  assign opc = instr[31:26];
  assign sel = instr[20:16];

  always_comb begin
    dec        = '0;
    dec.cond   = CND_EQ;
    unique case (opc)
      OPC_EQ, OPC_EQ_LK: begin
        dec.is_br  = 1'b1;
        dec.cond   = CND_EQ;
        dec.likely = (opc == OPC_EQ_LK);
      end
      OPC_NE, OPC_NE_LK: begin
        dec.is_br  = 1'b1;
        dec.cond   = CND_NE;
        dec.likely = (opc == OPC_NE_LK);
      end
      OPC_LEZ, OPC_LEZ_LK: begin
        dec.is_br  = 1'b1;
        dec.cond   = CND_LEZ;
        dec.likely = (opc == OPC_LEZ_LK);
      end
      OPC_GTZ, OPC_GTZ_LK: begin
        dec.is_br  = 1'b1;
        dec.cond   = CND_GTZ;
        dec.likely = (opc == OPC_GTZ_LK);
      end
      OPC_REGIMM: begin
        // valid selectors: bits 3:2 zero, bit 4 and bits 1:0 free
        if (sel[3:2] == 2'b00) begin
          dec.is_br  = 1'b1;
          dec.likely = sel[SEL_LIKELY_BIT];
          dec.link   = sel[SEL_LINK_BIT];
          dec.cond   = sel[SEL_GE_BIT] ? CND_GEZ : CND_LTZ;
        end
      end
      default: dec = '0;
    endcase
  end

endmodule

// File: rtl/brl_compare.sv
module brl_compare
  import brl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rs,
  input  logic [XLEN-1:0] rt,
  input  cond_e           cond,
  output logic            hit
);

  logic neg;
  logic zero;
  logic same;

  assign neg  = rs[XLEN-1];
  assign zero = (rs == '0);
  assign same = (rs == rt);

  always_comb begin
    unique case (cond)
      CND_EQ:  hit = same;
      CND_NE:  hit = !same;
      CND_LEZ: hit = neg || zero;
      CND_GTZ: hit = !neg && !zero;
      CND_LTZ: hit = neg;
      CND_GEZ: hit = !neg;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/brl_target.sv
module brl_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  seq4,
  output logic [XLEN-1:0]  seq8
);

  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] offs;

  assign offs   = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign seq4   = pc + XLEN'(4);
  assign seq8   = pc + XLEN'(8);
  assign target = seq4 + offs;

endmodule

// File: rtl/brl_resolve_unit.sv
module brl_resolve_unit
  import brl_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LINK_REG    = 31,
  parameter int IDX_W       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_rs,
  input  logic [XLEN-1:0] in_rt,
  input  logic [XLEN-1:0] in_pc,
  input  logic            in_wr_req,
  output logic            out_valid,
  output logic            out_is_branch,
  output logic            out_taken,
  output logic [XLEN-1:0] out_target,
  output logic            out_squash,
  output logic [XLEN-1:0] out_next_pc,
  output logic            out_link_we,
  output logic [IDX_W-1:0] out_link_idx,
  output logic [XLEN-1:0] out_link_data,
  output logic            out_wr_commit
);

  localparam int IMM_W = 16;

  // ---------------- reset release synchroniser ----------------
  logic rst_s;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_s = sync_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // ---------------- datapath pieces ----------------
  br_dec_t         dec;
  logic            hit;
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] seq4;
  logic [XLEN-1:0] seq8;

  brl_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  brl_compare #(.XLEN(XLEN)) u_cmp (
    .rs   (in_rs),
    .rt   (in_rt),
    .cond (dec.cond),
    .hit  (hit)
  );

  brl_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
    .pc     (in_pc),
    .imm    (in_instr[IMM_W-1:0]),
    .target (tgt),
    .seq4   (seq4),
    .seq8   (seq8)
  );

  // ---------------- next state ----------------
  logic            kill_q,   kill_d;
  logic            live;
  logic            br_d, taken_d, squash_d, link_d, commit_d;
  logic [XLEN-1:0] next_pc_d;

  always_comb begin
    live      = in_valid && !kill_q;
    br_d      = live && dec.is_br;
    taken_d   = br_d && hit;
    squash_d  = br_d && dec.likely && !hit;
    link_d    = br_d && dec.link;
    commit_d  = in_valid && in_wr_req && !kill_q;
    if (taken_d)   next_pc_d = tgt;
    else if (br_d) next_pc_d = seq8;
    else           next_pc_d = seq4;
    kill_d    = in_valid ? squash_d : kill_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_valid     <= 1'b0;
      out_is_branch <= 1'b0;
      out_taken     <= 1'b0;
      out_squash    <= 1'b0;
      out_link_we   <= 1'b0;
      out_wr_commit <= 1'b0;
      kill_q        <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      out_is_branch <= br_d;
      out_taken     <= taken_d;
      out_squash    <= squash_d;
      out_link_we   <= link_d;
      out_wr_commit <= commit_d;
      kill_q        <= kill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_target    <= '0;
      out_next_pc   <= '0;
      out_link_data <= '0;
    end else if (in_valid) begin
      out_target    <= tgt;
      out_next_pc   <= next_pc_d;
      out_link_data <= seq8;
    end
  end

  assign out_link_idx = IDX_W'(LINK_REG);

endmodule

// File: rtl/brl_checker.sv
module brl_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_s,
  input logic            in_valid,
  input logic [31:0]     in_instr,
  input logic [XLEN-1:0] in_pc,
  input logic            out_valid,
  input logic            out_is_branch,
  input logic            out_taken,
  input logic [XLEN-1:0] out_target,
  input logic            out_squash,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_link_we,
  input logic [XLEN-1:0] out_link_data,
  input logic            out_wr_commit
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)         pend_q <= 1'b0;
    else if (out_valid) pend_q <= out_squash;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> $past(in_valid));

  p_squash_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_s)
    out_squash |-> (out_valid && out_is_branch && !out_taken));

  p_ordinary_keeps_slot_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && ($past(in_instr[31:26]) inside {6'h04, 6'h05, 6'h06, 6'h07}))
      |-> !out_squash);

  p_link_addr_r7: assert property (@(posedge clk) disable iff (!rst_s)
    out_link_we |-> (out_link_data == $past(in_pc) + XLEN'(8)));

  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_s)
    out_taken |-> (out_next_pc == out_target));

  p_slot_annulled_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && pend_q) |-> (!out_wr_commit && !out_is_branch && !out_link_we));

  p_flags_need_valid_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (out_taken || out_squash || out_link_we || out_wr_commit || out_is_branch)
      |-> out_valid);

endmodule

bind brl_resolve_unit brl_checker #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_s         (rst_s),
  .in_valid      (in_valid),
  .in_instr      (in_instr),
  .in_pc         (in_pc),
  .out_valid     (out_valid),
  .out_is_branch (out_is_branch),
  .out_taken     (out_taken),
  .out_target    (out_target),
  .out_squash    (out_squash),
  .out_next_pc   (out_next_pc),
  .out_link_we   (out_link_we),
  .out_link_data (out_link_data),
  .out_wr_commit (out_wr_commit)
);

// File: tb/sim_brl_resolve_unit.sv
module sim_brl_resolve_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rs = '0;
  logic [31:0] in_rt = '0;
  logic [31:0] in_pc = '0;
  logic        in_wr_req = 1'b0;
  logic        out_valid, out_is_branch, out_taken, out_squash, out_link_we, out_wr_commit;
  logic [31:0] out_target, out_next_pc, out_link_data;
  logic [4:0]  out_link_idx;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brl_resolve_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_rs(in_rs), .in_rt(in_rt), .in_pc(in_pc), .in_wr_req(in_wr_req),
    .out_valid(out_valid), .out_is_branch(out_is_branch), .out_taken(out_taken),
    .out_target(out_target), .out_squash(out_squash), .out_next_pc(out_next_pc),
    .out_link_we(out_link_we), .out_link_idx(out_link_idx),
    .out_link_data(out_link_data), .out_wr_commit(out_wr_commit)
  );

  // ---------------- reference model ----------------
  bit          e_v, e_b, e_t, e_s, e_l, e_w, m_kill;
  logic [31:0] e_tgt, e_next, e_ldat;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic model_step();
    int         op, sel;
    bit         br, lk, ln, tk;
    int signed  a;
    e_v = in_valid; e_b = 0; e_t = 0; e_s = 0; e_l = 0; e_w = 0;
    if (!in_valid) return;
    e_ldat = in_pc + 8;
    e_tgt  = in_pc + 4 + {{14{in_instr[15]}}, in_instr[15:0], 2'b00};
    if (m_kill) begin
      m_kill = 0;
      e_next = in_pc + 4;
      return;
    end
    e_w = in_wr_req;
    op = int'(in_instr[31:26]); sel = int'(in_instr[20:16]);
    a = $signed(in_rs);
    br = 1; lk = 0; ln = 0; tk = 0;
    case (op)
      'h04: tk = (in_rs == in_rt);
      'h14: begin tk = (in_rs == in_rt); lk = 1; end
      'h05: tk = (in_rs != in_rt);
      'h15: begin tk = (in_rs != in_rt); lk = 1; end
      'h06: tk = (a <= 0);
      'h16: begin tk = (a <= 0); lk = 1; end
      'h07: tk = (a > 0);
      'h17: begin tk = (a > 0); lk = 1; end
      'h01: case (sel)
        'h00: tk = (a < 0);
        'h01: tk = (a >= 0);
        'h02: begin tk = (a < 0); lk = 1; end
        'h03: begin tk = (a >= 0); lk = 1; end
        'h10: begin tk = (a < 0); ln = 1; end
        'h11: begin tk = (a >= 0); ln = 1; end
        'h12: begin tk = (a < 0); ln = 1; lk = 1; end
        'h13: begin tk = (a >= 0); ln = 1; lk = 1; end
        default: br = 0;
      endcase
      default: br = 0;
    endcase
    e_b = br; e_t = br && tk; e_s = br && lk && !tk; e_l = br && ln;
    e_next = e_t ? e_tgt : (br ? in_pc + 8 : in_pc + 4);
    m_kill = e_s;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v = 0; e_b = 0; e_t = 0; e_s = 0; e_l = 0; e_w = 0; m_kill = 0;
    end else begin
      model_step();
      #5;
      if (!done) begin
        check(out_valid == e_v, "R2 valid", 32'(out_valid), 32'(e_v));
        check(out_is_branch == e_b, "R10 is_branch", 32'(out_is_branch), 32'(e_b));
        check(out_taken == e_t, "R3/R4 taken", 32'(out_taken), 32'(e_t));
        check(out_squash == e_s, "R5/R6 squash", 32'(out_squash), 32'(e_s));
        check(out_link_we == e_l, "R7 link_we", 32'(out_link_we), 32'(e_l));
        check(out_wr_commit == e_w, "R9 wr_commit", 32'(out_wr_commit), 32'(e_w));
        if (e_v)
          check(out_next_pc == e_next, "R8 next_pc", out_next_pc, e_next);
        if (e_b)
          check(out_target == e_tgt, "R2 target", out_target, e_tgt);
        if (e_l) begin
          check(out_link_data == e_ldat, "R7 link_data", out_link_data, e_ldat);
          check(out_link_idx == 5'd31, "R7 link_idx", 32'(out_link_idx), 32'd31);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] enc(int op, int sel, int imm);
    return {6'(op), 5'd3, 5'(sel), 16'(imm)};
  endfunction

  task automatic issue(logic [31:0] ins, logic [31:0] rs, logic [31:0] rt,
                       logic [31:0] pc, bit wr);
    @(negedge clk);
    in_valid = 1; in_instr = ins; in_rs = rs; in_rt = rt; in_pc = pc; in_wr_req = wr;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_wr_req = 0;
  endtask

  initial begin
    // R1: reset state, checked while reset is held
    repeat (3) @(negedge clk);
    check(!out_valid && !out_taken && !out_squash && !out_link_we && !out_wr_commit
          && !out_is_branch, "R1 reset flags", 32'(out_valid), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!out_valid && !out_wr_commit, "R1 after release", 32'(out_valid), 32'd0);

    // R3: equality, ordinary and likely, both outcomes
    issue(enc('h04, 7, 16), 32'd5, 32'd5, 32'h1000, 1);
    issue(enc('h04, 7, 16), 32'd5, 32'd6, 32'h1010, 1);
    issue(enc('h05, 7, 'hFFF0), 32'd1, 32'd2, 32'h2000, 0);
    issue(enc('h05, 7, 'hFFF0), 32'd9, 32'd9, 32'h2010, 0);
    issue(enc('h14, 7, 8), 32'd3, 32'd3, 32'h3000, 1);      // taken likely, slot lives
    issue(32'h0000_0021, 0, 0, 32'h3004, 1);
    issue(enc('h15, 7, 8), 32'd3, 32'd3, 32'h3100, 1);      // R5: not taken -> squash
    issue(32'h0000_0021, 0, 0, 32'h3104, 1);                // R9: slot annulled
    issue(32'h0000_0021, 0, 0, 32'h3108, 1);                // R9: kill cleared
    issue(enc('h14, 7, 8), 32'd3, 32'd4, 32'h3200, 0);      // squash
    issue(enc('h04, 7, 4), 32'd1, 32'd1, 32'h3204, 1);      // R9: branch in dead slot
    idle();
    issue(enc('h15, 7, 4), 32'd1, 32'd1, 32'h3300, 0);      // squash across idle gap
    idle(); idle();
    issue(enc('h01, 'h10, 4), 32'hFFFF_FFFF, 0, 32'h3304, 1); // R9: linked branch killed
    issue(32'h0000_0021, 0, 0, 32'h3308, 1);

    // R4: zero compares with signed boundaries
    for (int k = 0; k < 4; k++) begin
      logic [31:0] v;
      v = (k == 0) ? 32'h0 : (k == 1) ? 32'h8000_0000 : (k == 2) ? 32'h1 : 32'h7FFF_FFFF;
      issue(enc('h06, 0, 'h8000), v, 0, 32'h4000 + 32'(k*64), 0);
      issue(enc('h07, 0, 'h7FFF), v, 0, 32'h4004 + 32'(k*64), 0);
      issue(enc('h16, 0, 2), v, 0, 32'h4008 + 32'(k*64), 1);
      issue(enc('h17, 0, 2), v, 0, 32'h400C + 32'(k*64), 1);
      for (int s = 0; s < 4; s++) begin
        issue(enc('h01, s, 'hFFFE), v, 0, 32'h5000 + 32'(k*256 + s*16), 1);
        issue(enc('h01, 'h10 + s, 'h0010), v, 0, 32'h5004 + 32'(k*256 + s*16), 1); // R7
        issue(32'h0000_0021, 0, 0, 32'h5008 + 32'(k*256 + s*16), 1);
      end
    end

    // R10: non-branch opcodes and unused selectors
    issue(enc('h01, 'h04, 4), 32'h8000_0000, 0, 32'h6000, 1);
    issue(enc('h01, 'h08, 4), 32'h1, 0, 32'h6004, 1);
    issue(enc('h02, 0, 4), 0, 0, 32'h6008, 1);
    issue(enc('h24, 0, 4), 0, 0, 32'h600C, 0);

    // mixed pseudo-random traffic
    for (int n = 0; n < 3000; n++) begin
      int pick;
      logic [31:0] ins;
      pick = int'($urandom_range(0, 15));
      case (pick)
        0: ins = enc('h04, 0, int'($urandom));
        1: ins = enc('h05, 0, int'($urandom));
        2: ins = enc('h06, 0, int'($urandom));
        3: ins = enc('h07, 0, int'($urandom));
        4: ins = enc('h14, 0, int'($urandom));
        5: ins = enc('h15, 0, int'($urandom));
        6: ins = enc('h16, 0, int'($urandom));
        7: ins = enc('h17, 0, int'($urandom));
        8, 9: ins = enc('h01, int'($urandom_range(0, 31)), int'($urandom));
        default: ins = $urandom;
      endcase
      if ($urandom_range(0, 7) == 0) idle();
      else begin
        logic [31:0] a, b;
        a = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
        b = ($urandom_range(0, 1) == 0) ? a : $urandom;
        issue(ins, a, b, $urandom & 32'hFFFF_FFFC, 1'($urandom));
      end
    end
    idle(); idle(); idle();
    done = 1;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    compared++; mismatched++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule